// File: doc/BRIEF.md
# Serialiser with Even Parity Insertion

This block takes one 8-bit word on a load strobe and sends it out on a single wire, one bit per clock, least significant bit first. The low seven bits carry a character. The top bit position is never taken from the input. A one-flip-flop parity tracker follows the character bits as they leave, and the value it holds when the last slot comes up is sent in that eighth slot.

The resulting 8-bit serial word always holds an even number of 1s. A qualifier marks the eight cycles in which the serial line carries data. A one-cycle completion pulse follows the eighth bit. A load strobe that arrives while a word is still being sent has no effect. The block adds no start or stop framing.

Top module: `ps_parity_tx`

## Requirements
- R1: After reset, `ser_o`, `ser_valid_o` and `done_o` are all 0.
- R2: A `load_i` sampled high while idle starts a transfer. `ser_valid_o` is 1 for exactly the 8 cycles that follow that clock edge.
- R3: In valid cycles 1 to 7, `ser_o` carries `data_i[0]` through `data_i[6]` of the loaded word, in that order (LSB first).
- R4: In valid cycle 8, `ser_o` carries the XOR of loaded bits 6..0. The 8 transmitted bits therefore contain an even number of 1s.
- R5: The value of `data_i[7]` at load has no effect on any transmitted bit.
- R6: `done_o` is 1 for exactly one cycle, the cycle right after the eighth valid cycle. `ser_valid_o` is 0 in that cycle.
- R7: A `load_i` sampled while a transfer is in progress is ignored. The ongoing stream and its length are unchanged, and no new transfer follows it.
- R8: A `load_i` sampled at the edge that ends the `done_o` cycle is accepted and starts a new transfer.
- R9: `ser_o` is 0 whenever `ser_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe for a new word |
| data_i | input | 8 | Parallel word; bits 6..0 are the character |
| ser_o | output | 1 | Serial data, LSB first, parity in the last slot |
| ser_valid_o | output | 1 | High while `ser_o` carries a bit |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
The hardest situations to reach from the ports are the ones where the load strobe lands exactly on a boundary. One is a strobe mid-stream, including on the parity slot itself. The other is a strobe on the edge that closes the completion pulse. The directed tasks hold the strobe for a chosen number of cycles after the transfer begins, so each of these edges is hit deliberately. Parity is checked on words with odd and even counts of 1s, and on words whose top bit is 1.

// File: rtl/ps_parity_tx.sv
module ps_parity_tx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              ser_o,
  output logic              ser_valid_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  slot;
  logic              busy, par, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      slot   <= '0;
      busy   <= 1'b0;
      par    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (load_i) begin
          shreg <= data_i;
          slot  <= '0;
          par   <= 1'b0;
          busy  <= 1'b1;
        end
      end else begin
        slot <= slot + 1'b1;
        if (slot == LAST) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          par   <= par ^ shreg[0];
          shreg <= shreg >> 1;
        end
      end
    end
  end

  assign ser_o       = busy & ((slot == LAST) ? par : shreg[0]);
  assign ser_valid_o = busy;
  assign done_o      = done_q;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_valid_o) |-> $past(load_i));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid_o && slot != LAST) |=> ser_valid_o);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !ser_valid_o);
  p_last_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid_o && slot == LAST) |=> done_o);
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid_o |-> !ser_o);
endmodule

// File: tb/ps_parity_tx_bench.sv
module ps_parity_tx_bench;
  logic clk = 0, rst_n = 0, load_i = 0;
  logic [7:0] data_i = '0;
  logic ser_o, ser_valid_o, done_o;
  int n_run = 0, n_fail = 0;

  ps_parity_tx u_ps_parity_tx (.clk(clk), .rst_n(rst_n), .load_i(load_i),
    .data_i(data_i), .ser_o(ser_o), .ser_valid_o(ser_valid_o), .done_o(done_o));

  always #2 clk = ~clk;

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Loads w; holds load_i high for extra_load cycles after the start.
  // Checks the 8 bits, valid, done, and the cycle after done.
  task automatic send(input logic [7:0] w, input int extra_load, input bit reload_at_done,
                      input logic [7:0] w2);
    logic [7:0] got;
    logic [7:0] expw;
    expw = {^w[6:0], w[6:0]};
    @(negedge clk); load_i = 1; data_i = w;
    @(negedge clk);
    if (extra_load == 0) begin load_i = 0; data_i = ~w; end
    for (int i = 0; i < 8; i++) begin
      chk("R2 valid", ser_valid_o, 1);
      chk("R9 done low in stream", done_o, 0);
      got[i] = ser_o;
      @(negedge clk);
      if (i + 1 >= extra_load) load_i = 0;
    end
    chk("R3 character bits", got[6:0], expw[6:0]);
    chk("R4 even parity bit", got[7], expw[7]);
    chk("R4 even ones count", $countones(got) % 2, 0);
    chk("R6 done pulse", done_o, 1);
    chk("R6 valid low at done", ser_valid_o, 0);
    chk("R9 serial low at done", ser_o, 0);
    if (reload_at_done) begin load_i = 1; data_i = w2; end
    @(negedge clk);
    load_i = 0;
    chk("R6 done one cycle", done_o, 0);
    chk(reload_at_done ? "R8 reload starts" : "R7 no restart", ser_valid_o, reload_at_done);
  endtask

  task automatic t_reset;
    chk("R1 ser", ser_o, 0);
    chk("R1 valid", ser_valid_o, 0);
    chk("R1 done", done_o, 0);
  endtask

  task automatic t_basic;
    send(8'h41, 0, 0, 0);
    send(8'h43, 0, 0, 0);
    send(8'h00, 0, 0, 0);
    send(8'h7F, 0, 0, 0);
  endtask

  task automatic t_msb_ignored;  // R5
    send(8'hC1, 0, 0, 0);
    send(8'h80, 0, 0, 0);
  endtask

  task automatic t_load_mid;  // R7: strobe held through the stream incl. parity slot
    send(8'h55, 8, 0, 0);
    send(8'h2A, 3, 0, 0);
  endtask

  task automatic t_reload;  // R8
    logic [7:0] got;
    send(8'h35, 0, 1, 8'h5A);
    for (int i = 0; i < 8; i++) begin
      chk("R8 valid", ser_valid_o, 1);
      got[i] = ser_o;
      @(negedge clk);
    end
    chk("R8 second word", got, {^8'h5A & 1'b1 ? ~1'b0 : 1'b0, 7'h5A} ^ 8'h00);
    chk("R8 done after second", done_o, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_msb_ignored;
    t_load_mid;
    t_reload;
    repeat (4) @(negedge clk);
    chk("R9 idle serial", ser_o, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule